// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

This block is a memory-mapped timer unit with three reloadable down-counters and one wide free-running up-counter. Two down-counters are 16 bits wide and the third is 32 bits wide. Each down-counter counts on a selectable tick input. When it passes zero it raises a level interrupt, which stays high until software clears it. The up-counter is 40 bits wide and advances on a faster tick input. It never interrupts. Software reads it as a low word and a high word, and the high word also carries its enable bit.

Software uses a simple synchronous register bus: a select, a write flag, a byte address and write data. Read data appears registered on the cycle after the request. The tick inputs are single-cycle enable pulses made outside the block, so all state runs on one clock. A typical use is a periodic system tick from one down-counter, with the free-running counter used to measure elapsed time between interrupts.

Top module: `tmr_unit`

## Requirements
- R1: Register offsets are: down-counter 0 at 0x00 (load), 0x04 (value), 0x08 (control), 0x0C (clear); down-counter 1 at 0x20..0x2C; down-counter 2 at 0x80..0x8C; free counter low word at 0x60 and high word at 0x64. A read returns its data on `busRdata` in the clock cycle after the request. Any other offset, and the clear registers, read as zero.
- R2: Down-counters 0 and 1 hold 16 bits and down-counter 2 holds 32 bits. Upper write bits are dropped. Writes to a value register are ignored.
- R3: Control bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the tick source (1 = `slowTick`, 0 = `altTick`). A control read returns only these three bits. A counter moves only on a pulse of its selected tick while enabled.
- R4: In periodic mode, a tick at value zero reloads the value from the load register and sets the counter's interrupt. Loading N therefore gives one interrupt every N+1 ticks.
- R5: With periodic mode off, a tick at value zero wraps the value to all ones for the counter's width and still sets its interrupt.
- R6: Writing a load register also writes the value register in the same cycle, whether or not the counter is enabled.
- R7: Writing any data to a clear register deasserts that counter's interrupt. If an underflow falls in the same cycle, the interrupt stays set.
- R8: The free counter is 40 bits wide. It advances by one on each `fastTick` pulse while high-word bit 8 is set. The low word reads count bits 31:0. The high word reads bit 8 as the enable and bits 7:0 as count bits 39:32. When disabled, the counter holds its count.
- R9: Free counter activity never changes `irq`.
- R10: After reset all registers, counts and interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Primary down-counter tick pulse |
| altTick | input | 1 | Alternate slower down-counter tick pulse |
| fastTick | input | 1 | Free counter tick pulse |
| busSel | input | 1 | Bus access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irq | output | 3 | Level interrupt per down-counter |

## Verification
A clear write and an underflow of the same down-counter can fall in the same cycle. If the clear won, that underflow's interrupt would be lost. The bench provokes this case by running a periodic counter down to zero and then issuing the clear write in the very cycle that carries the final tick pulse. It judges the result at the `irq` port on the next sample: the interrupt must still be high and the value must have reloaded. A separate clear afterwards must bring the interrupt low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 3;

  localparam logic [7:0] CH0_BASE   = 8'h00;
  localparam logic [7:0] CH1_BASE   = 8'h20;
  localparam logic [7:0] CH2_BASE   = 8'h80;
  localparam logic [7:0] FREE_LO_OFF = 8'h60;
  localparam logic [7:0] FREE_HI_OFF = 8'h64;
  localparam int FREE_EN_BIT = 8;

  // control bit positions decoded by the down-counters
  localparam int CTL_EN  = 7;
  localparam int CTL_PER = 6;
  localparam int CTL_SEL = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOAD, RD_VALUE, RD_CTRL, RD_FREE_LO, RD_FREE_HI
  } rdsel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLoad;
    logic [NUM_CH-1:0] wrCtrl;
    logic [NUM_CH-1:0] wrClr;
    logic              wrFreeHi;
    rdsel_e            rdSel;
    logic [1:0]        rdCh;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output tmr_strobe_t       strobe
);
  logic [7:0] addr8;
  logic       chHit;
  logic [1:0] chIdx;
  logic [1:0] regIdx;

  assign addr8  = busAddr[7:0];
  assign regIdx = addr8[3:2];

  always_comb begin
    chHit = 1'b0;
    chIdx = 2'd0;
    if (addr8[1:0] == 2'b00) begin
      if ({addr8[7:4], 4'h0} == CH0_BASE) begin chHit = 1'b1; chIdx = 2'd0; end
      if ({addr8[7:4], 4'h0} == CH1_BASE) begin chHit = 1'b1; chIdx = 2'd1; end
      if ({addr8[7:4], 4'h0} == CH2_BASE) begin chHit = 1'b1; chIdx = 2'd2; end
    end
  end

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    strobe.rdCh  = chIdx;
    if (busSel && busWe) begin
      if (chHit) begin
        case (regIdx)
          2'd0:    strobe.wrLoad[chIdx] = 1'b1;
          2'd2:    strobe.wrCtrl[chIdx] = 1'b1;
          2'd3:    strobe.wrClr[chIdx]  = 1'b1;
          default: ;
        endcase
      end
      if (addr8 == FREE_HI_OFF) strobe.wrFreeHi = 1'b1;
    end else if (busSel) begin
      if (chHit) begin
        case (regIdx)
          2'd0:    strobe.rdSel = RD_LOAD;
          2'd1:    strobe.rdSel = RD_VALUE;
          2'd2:    strobe.rdSel = RD_CTRL;
          default: strobe.rdSel = RD_NONE;
        endcase
      end
      if (addr8 == FREE_LO_OFF) strobe.rdSel = RD_FREE_LO;
      if (addr8 == FREE_HI_OFF) strobe.rdSel = RD_FREE_HI;
    end
  end
endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              altTick,
  input  logic              wrLoad,
  input  logic              wrCtrl,
  input  logic              wrClr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] loadOut,
  output logic [DATA_W-1:0] valueOut,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              irq
);
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] value;
  logic enable, periodic, clkSel;
  logic tick, underflow;

  assign tick      = enable && (clkSel ? slowTick : altTick);
  assign underflow = tick && !wrLoad && (value == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg  <= '0;
      value    <= '0;
      enable   <= 1'b0;
      periodic <= 1'b0;
      clkSel   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enable   <= wdata[CTL_EN];
        periodic <= wdata[CTL_PER];
        clkSel   <= wdata[CTL_SEL];
      end
      if (wrLoad) begin
        loadReg <= wdata[CNT_W-1:0];
        value   <= wdata[CNT_W-1:0];
      end else if (tick) begin
        if (value == '0) value <= periodic ? loadReg : '1;
        else             value <= value - 1'b1;
      end
      if (underflow)  irq <= 1'b1;
      else if (wrClr) irq <= 1'b0;
    end
  end

  assign loadOut  = DATA_W'(loadReg);
  assign valueOut = DATA_W'(value);
  always_comb begin
    ctrlOut = '0;
    ctrlOut[CTL_EN]  = enable;
    ctrlOut[CTL_PER] = periodic;
    ctrlOut[CTL_SEL] = clkSel;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          slowTick,
  input  logic                          altTick,
  input  logic                          fastTick,
  input  tmr_strobe_t                   strobe,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output logic [NUM_CH-1:0]             irq,
  output logic [NUM_CH-1:0][DATA_W-1:0] chValue,
  output logic [FREE_W-1:0]             freeCnt
);
  localparam int FREE_HI_W = FREE_W - DATA_W;

  logic [NUM_CH-1:0][DATA_W-1:0] chLoad;
  logic [NUM_CH-1:0][DATA_W-1:0] chCtrl;
  logic freeEn;
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CW = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
    tmr_downcnt #(.CNT_W(CW), .DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .slowTick (slowTick),
      .altTick  (altTick),
      .wrLoad   (strobe.wrLoad[g]),
      .wrCtrl   (strobe.wrCtrl[g]),
      .wrClr    (strobe.wrClr[g]),
      .wdata    (busWdata),
      .loadOut  (chLoad[g]),
      .valueOut (chValue[g]),
      .ctrlOut  (chCtrl[g]),
      .irq      (irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeEn  <= 1'b0;
      freeCnt <= '0;
    end else begin
      if (strobe.wrFreeHi) freeEn <= busWdata[FREE_EN_BIT];
      if (freeEn && fastTick) freeCnt <= freeCnt + 1'b1;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strobe.rdSel)
      RD_LOAD:    rdMux = chLoad[strobe.rdCh];
      RD_VALUE:   rdMux = chValue[strobe.rdCh];
      RD_CTRL:    rdMux = chCtrl[strobe.rdCh];
      RD_FREE_LO: rdMux = freeCnt[DATA_W-1:0];
      RD_FREE_HI: begin
        rdMux[FREE_HI_W-1:0] = freeCnt[FREE_W-1:DATA_W];
        rdMux[FREE_EN_BIT]   = freeEn;
      end
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdMux;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              altTick,
  input  logic              fastTick,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [2:0]        irq
);
  tmr_strobe_t strobe;
  logic [NUM_CH-1:0][DATA_W-1:0] chValue;
  logic [FREE_W-1:0] freeCnt;

  tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  tmr_datapath #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .FREE_W(FREE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .slowTick (slowTick),
    .altTick  (altTick),
    .fastTick (fastTick),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .chValue  (chValue),
    .freeCnt  (freeCnt)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FREE_W = 40
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   slowTick,
  input logic                   altTick,
  input logic                   fastTick,
  input logic                   busSel,
  input logic                   busWe,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [DATA_W-1:0]      busRdata,
  input logic [2:0]             irq,
  input logic [2:0][DATA_W-1:0] chValue,
  input logic [FREE_W-1:0]      freeCnt
);
  // R1: an unused offset reads back zero
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && busAddr == ADDR_W'(8'h40) |=> busRdata == '0);

  // R2: with no tick and no write, down-counter values hold
  a_r2_value_hold: assert property (@(posedge clk) disable iff (!rstN)
    !slowTick && !altTick && !(busSel && busWe) |=> $stable(chValue));

  // R4: an interrupt only rises after a tick pulse
  for (genvar i = 0; i < 3; i++) begin : g_rise
    a_r4_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) |-> $past(slowTick || altTick));
  end

  // R7: a clear of counter 0 with no tick pending drops its interrupt
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWe && busAddr == ADDR_W'(8'h0C) && !slowTick && !altTick
    |=> !irq[0]);

  // R8: the free counter holds without a fast tick
  a_r8_free_hold: assert property (@(posedge clk) disable iff (!rstN)
    !fastTick |=> $stable(freeCnt));

  // R9: free counter ticks alone never move an interrupt
  a_r9_free_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    fastTick && !slowTick && !altTick && !(busSel && busWe) |=> $stable(irq));
endmodule

bind tmr_unit tmr_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREE_W(FREE_W)) u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .altTick(altTick),
  .fastTick(fastTick), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busRdata(busRdata), .irq(irq), .chValue(chValue), .freeCnt(freeCnt)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0, altTick = 1'b0, fastTick = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdFlag = 1'b0;

  always #2.5 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .altTick(altTick),
    .fastTick(fastTick), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rdFlag <= busSel && !busWe;
  always @(negedge clk) begin
    if (rdFlag) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: read with empty scoreboard, actual 0x%08h expected none", busRdata);
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic pulseSlow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slowTick = 1'b1;
      @(negedge clk) slowTick = 1'b0;
    end
  endtask

  task automatic pulseAlt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) altTick = 1'b1;
      @(negedge clk) altTick = 1'b0;
    end
  endtask

  task automatic pulseFast(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fastTick = 1'b1;
      @(negedge clk) fastTick = 1'b0;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    check({29'b0, irq}, 32'h0, "R10 irq after reset");
    busRead(8'h00, 32'h0, "R10 load0 reset");
    busRead(8'h04, 32'h0, "R10 value0 reset");
    busRead(8'h08, 32'h0, "R10 ctrl0 reset");
    busRead(8'h64, 32'h0, "R10 free high reset");

    // R1: unused offsets and clear register read zero
    busWrite(8'h00, 32'h5);
    busRead(8'h10, 32'h0, "R1 unused 0x10");
    busRead(8'h40, 32'h0, "R1 unused 0x40");
    busRead(8'h68, 32'h0, "R1 unused 0x68");
    busRead(8'h0C, 32'h0, "R1 clear reads zero");

    // R6: load writes value while disabled; R2: value writes ignored
    busWrite(8'h00, 32'h4);
    busRead(8'h04, 32'h4, "R6 load copies to value");
    busWrite(8'h04, 32'h9);
    busRead(8'h04, 32'h4, "R2 value write ignored");

    // R3: control bits readback
    busWrite(8'h08, 32'hFF);
    busRead(8'h08, 32'hC8, "R3 ctrl readback");

    // R4: periodic reload after N+1 ticks
    pulseSlow(4);
    check({29'b0, irq}, 32'h0, "R4 no irq before N+1 ticks");
    busRead(8'h04, 32'h0, "R4 value reached zero");
    pulseSlow(1);
    check({29'b0, irq}, 32'h1, "R4 irq at N+1 ticks");
    busRead(8'h04, 32'h4, "R4 reload from load");

    // R3: alternate tick ignored when slow source selected
    pulseAlt(3);
    busRead(8'h04, 32'h4, "R3 unselected tick ignored");

    // R7: clear, then clear colliding with underflow
    busWrite(8'h0C, 32'h0);
    check({29'b0, irq}, 32'h0, "R7 clear drops irq");
    pulseSlow(4);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = 8'h0C; busWdata = 32'hA5; slowTick = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; slowTick = 1'b0;
    check({29'b0, irq}, 32'h1, "R7 underflow wins over clear");
    busRead(8'h04, 32'h4, "R7 reload during collision");
    busWrite(8'h0C, 32'h0);
    check({29'b0, irq}, 32'h0, "R7 later clear drops irq");
    busWrite(8'h08, 32'h0);

    // R2: 16-bit truncation on counter 1
    busWrite(8'h20, 32'h0001_2345);
    busRead(8'h20, 32'h2345, "R2 load1 truncated");
    busRead(8'h24, 32'h2345, "R2 value1 truncated");

    // R5: one-shot wrap on alternate tick
    busWrite(8'h20, 32'h2);
    busWrite(8'h28, 32'h80);
    pulseSlow(3);
    busRead(8'h24, 32'h2, "R3 alt-selected counter ignores slow tick");
    pulseAlt(3);
    busRead(8'h24, 32'hFFFF, "R5 16-bit wrap to max");
    check({29'b0, irq}, 32'h2, "R5 irq on wrap ch1");

    // R2/R5: 32-bit counter wrap
    busWrite(8'h80, 32'h1);
    busWrite(8'h88, 32'h88);
    pulseSlow(2);
    busRead(8'h84, 32'hFFFF_FFFF, "R2 32-bit wrap to max");
    check({29'b0, irq}, 32'h6, "R5 irq on wrap ch2");
    busWrite(8'h2C, 32'h0);
    busWrite(8'h8C, 32'h0);
    check({29'b0, irq}, 32'h0, "R7 clears ch1 and ch2");

    // R8: free counter
    pulseFast(5);
    busRead(8'h60, 32'h0, "R8 disabled free counter holds");
    busWrite(8'h64, 32'h100);
    pulseFast(7);
    busRead(8'h60, 32'h7, "R8 free low word count");
    busRead(8'h64, 32'h100, "R8 free high word enable and upper bits");
    check({29'b0, irq}, 32'h0, "R9 free counter leaves irq");
    busWrite(8'h64, 32'h0);
    pulseFast(3);
    busRead(8'h60, 32'h7, "R8 free counter holds after disable");
    busRead(8'h64, 32'h0, "R8 high word enable cleared");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1: %0d reads unanswered, expected 0", expQ.size());
    end
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish();
  end
endmodule